// File: doc/BRIEF.md
# Arithmetic condition code generator

This block turns the operands of an integer operation into a 2-bit condition code. Each request carries an operation selector, a width flag and three data words: the first operand, the second operand and the result that the datapath produced. The generator does no arithmetic of its own. It only classifies these values, so it can sit next to an execution unit and give the code a branch or a flag register needs.

The block handles the following classes. Signed, unsigned and against-zero compares. Signed and logical add and subtract. Absolute value, negative absolute value, complement and a nonzero test. Four selectors also return a fixed code. Every class works in a narrow (32-bit) mode or a full (64-bit) mode. The block registers a request on the cycle its valid strobe is high, and the code appears on the next cycle together with a valid flag. A selector outside the defined set returns code 0 and raises an error flag for that one result.

Top module: `cc_gen`

## Requirements
- R1: A request is captured at a rising clock edge where `in_valid_i` is high. `out_valid_o` is high for the cycle after each such edge and low after any edge where `in_valid_i` is low. While `out_valid_o` is low, `cc_o` and `err_o` are 0. A synchronous active-low reset clears all three outputs.
- R2: The selector encoding on `sel_i` is: 0..3 constant, 4 signed compare, 5 unsigned compare, 6 compare result with zero, 7 signed add, 8 logical add, 9 signed subtract, 10 logical subtract, 11 absolute value, 12 negative absolute value, 13 complement, 14 nonzero test. Any value from 15 to 31 gives `cc_o` = 0 and `err_o` = 1 for that one result.
- R3: Signed compare of first operand A with second operand B gives 0 when they are equal, 1 when A < B and 2 when A > B.
- R4: Unsigned compare gives the same three codes, with the operands taken as unsigned.
- R5: Compare with zero looks at the result operand. It gives 0 for zero, 1 for negative and 2 for positive.
- R6: Signed add gives 3 when A > 0, B > 0 and the result is negative, or when A < 0, B < 0 and the result is positive. Otherwise it gives 1 for a negative result, 2 for a positive result and 0 for zero.
- R7: Signed subtract gives 3 when A > 0, B < 0 and the result is negative, or when A < 0, B > 0 and the result is positive. Otherwise it encodes the sign of the result as in R6. A zero operand is neither positive nor negative.
- R8: Logical add derives the carry as result < A (unsigned). It gives 0 for a zero result with no carry, 2 for a zero result with carry, 1 for a nonzero result with no carry and 3 for a nonzero result with carry.
- R9: Logical subtract gives 2 for a zero result. For a nonzero result it gives 1 when B > A (unsigned, a borrow) and 3 otherwise.
- R10: Absolute value looks at the result operand. It gives 3 for the most negative value of the width, 1 for any other nonzero value and 0 for zero.
- R11: Complement gives 3 for a most-negative result, 1 for another negative result, 2 for a positive result and 0 for zero.
- R12: Negative absolute value and the nonzero test give 0 for a zero result and 1 otherwise.
- R13: The constant selectors 0..3 return their own value as the code, whatever the operands hold.
- R14: With `wide_i` = 0 only bits 31..0 of each operand count, and bit 31 is the sign. With `wide_i` = 1 all 64 bits count, and bit 63 is the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| sel_i | input | 5 | Operation selector |
| wide_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| res_i | input | 64 | Result of the operation |
| out_valid_o | output | 1 | Code valid, one cycle after the request |
| cc_o | output | 2 | Condition code |
| err_o | output | 1 | Unknown selector flag |

## Verification
The hardest cases to reach are the boundaries where the code depends on bits the other width mode ignores. Examples are a result whose low word is zero or most-negative while its upper word is not, or a logical add whose carry appears only in the 32-bit view. The stimulus uses crafted operand triples whose upper and lower halves disagree and sends the same triple in both width modes, so the code must change with `wide_i` alone. The overflow rules for signed add and subtract are driven at their edges: both operands at the extreme values, and a zero first operand against the most negative second operand.

// File: rtl/ccgen_pkg.sv
// Package: shared selector encoding and per-operand flag type for the
// condition code generator. Assumes a 5-bit selector field.
package ccgen_pkg;

    localparam int SEL_W = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_K0    = 5'd0,
        SEL_K1    = 5'd1,
        SEL_K2    = 5'd2,
        SEL_K3    = 5'd3,
        SEL_CMP_S = 5'd4,
        SEL_CMP_U = 5'd5,
        SEL_CMP_Z = 5'd6,
        SEL_ADD_S = 5'd7,
        SEL_ADD_L = 5'd8,
        SEL_SUB_S = 5'd9,
        SEL_SUB_L = 5'd10,
        SEL_ABS   = 5'd11,
        SEL_NABS  = 5'd12,
        SEL_CPL   = 5'd13,
        SEL_NZ    = 5'd14
    } cc_sel_e;

    localparam logic [SEL_W-1:0] SEL_LAST = SEL_NZ;

    typedef struct packed {
        logic neg;
        logic zero;
        logic minneg;
    } opnd_flags_t;

endpackage

// File: rtl/ccgen_capture.sv
// Module: input stage. Registers selector, width flag and the three
// operands when the request strobe is high; the valid bit follows the
// strobe by one cycle. Assumes synchronous active-low reset.
module ccgen_capture #(
    parameter int DATA_W = 64,
    parameter int SEL_W  = 5,
    parameter int N_OPND = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wide,
    input  logic [DATA_W-1:0] opnd   [N_OPND],
    output logic              valid_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic              wide_q,
    output logic [DATA_W-1:0] opnd_q [N_OPND]
);

    // Track which cycles carry a captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= in_valid;
    end

    // Hold the request control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            wide_q <= 1'b0;
        end else if (in_valid) begin
            sel_q  <= sel;
            wide_q <= wide;
        end
    end

    // Hold each operand word.
    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        always_ff @(posedge clk) begin
            if (!rst_n)        opnd_q[g] <= '0;
            else if (in_valid) opnd_q[g] <= opnd[g];
        end
    end

endmodule

// File: rtl/ccgen_view.sv
// Module: width view of one operand. Produces the zero- and sign-extended
// value seen in the selected width, plus sign, zero and most-negative
// flags. Assumes NARROW_W < DATA_W.
module ccgen_view
    import ccgen_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] ext_u,
    output logic [DATA_W-1:0] ext_s,
    output opnd_flags_t       flags
);

    localparam int PAD_W = DATA_W - NARROW_W;
    localparam logic [DATA_W-1:0]   MIN_WIDE   = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [NARROW_W-1:0] MIN_NARROW = {1'b1, {(NARROW_W-1){1'b0}}};

    logic [NARROW_W-1:0] low;
    logic                low_sign;

    assign low      = value[NARROW_W-1:0];
    assign low_sign = low[NARROW_W-1];

    // Extend the operand as seen in the selected width.
    always_comb begin
        if (wide) begin
            ext_u = value;
            ext_s = value;
        end else begin
            ext_u = {{PAD_W{1'b0}}, low};
            ext_s = {{PAD_W{low_sign}}, low};
        end
    end

    // Classify sign, zero and most-negative for the selected width.
    always_comb begin
        flags.neg    = wide ? value[DATA_W-1] : low_sign;
        flags.zero   = (ext_u == '0);
        flags.minneg = wide ? (value == MIN_WIDE) : (low == MIN_NARROW);
    end

endmodule

// File: rtl/ccgen_decode.sv
// Module: condition code decoder. Maps the selector and the width-adjusted
// operands to a 2-bit code and flags selectors outside the defined set.
// Purely combinational; assumes operands already extended by ccgen_view.
module ccgen_decode
    import ccgen_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] a_u,
    input  logic [DATA_W-1:0] a_s,
    input  logic [DATA_W-1:0] b_u,
    input  logic [DATA_W-1:0] b_s,
    input  logic [DATA_W-1:0] r_u,
    input  opnd_flags_t       a_f,
    input  opnd_flags_t       b_f,
    input  opnd_flags_t       r_f,
    output logic [1:0]        code,
    output logic              unknown
);

    function automatic logic [1:0] sign_code(input opnd_flags_t f);
        if (f.zero)     return 2'd0;
        else if (f.neg) return 2'd1;
        else            return 2'd2;
    endfunction

    function automatic logic is_pos(input opnd_flags_t f);
        return !f.neg && !f.zero;
    endfunction

    logic carry, borrow, add_ovf, sub_ovf;

    // Derive carry, borrow and signed overflow conditions.
    always_comb begin
        carry   = (r_u < a_u);
        borrow  = (b_u > a_u);
        add_ovf = (is_pos(a_f) && is_pos(b_f) && r_f.neg) ||
                  (a_f.neg && b_f.neg && is_pos(r_f));
        sub_ovf = (is_pos(a_f) && b_f.neg && r_f.neg) ||
                  (a_f.neg && is_pos(b_f) && is_pos(r_f));
    end

    // Select the code for the requested operation class.
    always_comb begin
        code    = 2'd0;
        unknown = 1'b0;
        case (sel)
            SEL_K0, SEL_K1, SEL_K2, SEL_K3:
                code = sel[1:0];
            SEL_CMP_S:
                code = (a_s == b_s) ? 2'd0 :
                       ($signed(a_s) < $signed(b_s)) ? 2'd1 : 2'd2;
            SEL_CMP_U:
                code = (a_u == b_u) ? 2'd0 : (a_u < b_u) ? 2'd1 : 2'd2;
            SEL_CMP_Z:
                code = sign_code(r_f);
            SEL_ADD_S:
                code = add_ovf ? 2'd3 : sign_code(r_f);
            SEL_ADD_L:
                code = {carry, !r_f.zero};
            SEL_SUB_S:
                code = sub_ovf ? 2'd3 : sign_code(r_f);
            SEL_SUB_L:
                code = r_f.zero ? 2'd2 : (borrow ? 2'd1 : 2'd3);
            SEL_ABS:
                code = r_f.minneg ? 2'd3 : (r_f.zero ? 2'd0 : 2'd1);
            SEL_NABS, SEL_NZ:
                code = {1'b0, !r_f.zero};
            SEL_CPL:
                code = r_f.minneg ? 2'd3 : sign_code(r_f);
            default:
                unknown = 1'b1;
        endcase
    end

endmodule

// File: rtl/cc_gen.sv
// Module: top of the condition code generator. Captures a request on the
// strobe, views each operand in the selected width and decodes the code,
// presenting it one cycle after the request. Synchronous active-low reset.
module cc_gen
    import ccgen_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [4:0]        sel_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] res_i,
    output logic              out_valid_o,
    output logic [1:0]        cc_o,
    output logic              err_o
);

    localparam int N_OPND = 3;
    localparam int IDX_A  = 0;
    localparam int IDX_B  = 1;
    localparam int IDX_R  = 2;

    logic [DATA_W-1:0] opnd   [N_OPND];
    logic [DATA_W-1:0] opnd_q [N_OPND];
    logic [DATA_W-1:0] ext_u  [N_OPND];
    logic [DATA_W-1:0] ext_s  [N_OPND];
    opnd_flags_t       flags  [N_OPND];
    logic              valid_q, wide_q, unknown;
    logic [SEL_W-1:0]  sel_q;
    logic [1:0]        code;

    assign opnd[IDX_A] = opa_i;
    assign opnd[IDX_B] = opb_i;
    assign opnd[IDX_R] = res_i;

    ccgen_capture #(.DATA_W(DATA_W), .SEL_W(SEL_W), .N_OPND(N_OPND)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid_i),
        .sel      (sel_i),
        .wide     (wide_i),
        .opnd     (opnd),
        .valid_q  (valid_q),
        .sel_q    (sel_q),
        .wide_q   (wide_q),
        .opnd_q   (opnd_q)
    );

    for (genvar g = 0; g < N_OPND; g++) begin : g_view
        ccgen_view #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_view (
            .wide  (wide_q),
            .value (opnd_q[g]),
            .ext_u (ext_u[g]),
            .ext_s (ext_s[g]),
            .flags (flags[g])
        );
    end

    ccgen_decode #(.DATA_W(DATA_W)) u_decode (
        .sel     (sel_q),
        .a_u     (ext_u[IDX_A]),
        .a_s     (ext_s[IDX_A]),
        .b_u     (ext_u[IDX_B]),
        .b_s     (ext_s[IDX_B]),
        .r_u     (ext_u[IDX_R]),
        .a_f     (flags[IDX_A]),
        .b_f     (flags[IDX_B]),
        .r_f     (flags[IDX_R]),
        .code    (code),
        .unknown (unknown)
    );

    // Gate the outputs with the captured valid bit.
    always_comb begin
        out_valid_o = valid_q;
        cc_o        = valid_q ? code : 2'd0;
        err_o       = valid_q && unknown;
    end

    // R1: a captured request yields exactly one valid result next cycle.
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!out_valid_o && cc_o == 2'd0 && !err_o));

    // R2: error results carry code 0, and out-of-range selectors raise it.
    a_r2_err_code: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (out_valid_o && cc_o == 2'd0));
    a_r2_err_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && sel_i > SEL_LAST) |=> err_o);

    // R13: constant selectors return their own value.
    a_r13_const: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && sel_i < 5'd4) |=> (cc_o == $past(sel_i[1:0]) && !err_o));

    // R8: a nonzero 64-bit logical-add result always sets the low code bit.
    a_r8_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && wide_i && sel_i == SEL_ADD_L && res_i != '0) |=> cc_o[0]);

endmodule

// File: tb/test_cc_gen.sv
module test_cc_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [4:0]  sel_i = '0;
    logic        wide_i = 1'b0;
    logic [63:0] opa_i = '0, opb_i = '0, res_i = '0;
    logic        out_valid_o, err_o;
    logic [1:0]  cc_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2 clk = ~clk;

    cc_gen i_cc_gen (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .sel_i(sel_i),
        .wide_i(wide_i), .opa_i(opa_i), .opb_i(opb_i), .res_i(res_i),
        .out_valid_o(out_valid_o), .cc_o(cc_o), .err_o(err_o)
    );

    task automatic check(string req, logic v, logic [1:0] c, logic e);
        n_checks++;
        if (out_valid_o !== v || cc_o !== c || err_o !== e) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b cc=%0d err=%0b, expected valid=%0b cc=%0d err=%0b",
                     req, out_valid_o, cc_o, err_o, v, c, e);
        end
    endtask

    // Drive one request and check the result one cycle later.
    task automatic run(string req, logic [4:0] s, logic w, logic [63:0] a,
                       logic [63:0] b, logic [63:0] r, logic [1:0] exp_cc,
                       logic exp_err = 1'b0);
        @(negedge clk);
        in_valid_i = 1'b1; sel_i = s; wide_i = w;
        opa_i = a; opb_i = b; res_i = r;
        @(posedge clk); #1;
        check(req, 1'b1, exp_cc, exp_err);
        in_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", 1'b0, 2'd0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_idle();
        run("R1 capture", 5'd6, 1'b1, 0, 0, 64'd9, 2'd2);
        // Inputs change with the strobe low: nothing is captured.
        @(negedge clk); sel_i = 5'd3; res_i = 64'd1;
        @(posedge clk); #1 check("R1 no strobe", 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_cmp();
        run("R3 equal",   5'd4, 1'b1, 64'd5, 64'd5, 0, 2'd0);
        run("R3 less",    5'd4, 1'b1, ONES, 64'd1, 0, 2'd1);
        run("R3 greater", 5'd4, 1'b1, 64'd1, ONES, 0, 2'd2);
        run("R4 greater", 5'd5, 1'b1, ONES, 64'd1, 0, 2'd2);
        run("R4 less",    5'd5, 1'b1, 64'd1, ONES, 0, 2'd1);
        run("R4 equal",   5'd5, 1'b1, 64'd7, 64'd7, 0, 2'd0);
        run("R14 R3 high bits ignored", 5'd4, 1'b0, 64'h1_0000_0001, 64'h2_0000_0001, 0, 2'd0);
        run("R14 R3 sign bit31",        5'd4, 1'b0, 64'h8000_0000, 64'd1, 0, 2'd1);
        run("R14 R4 narrow",            5'd5, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'd2, 0, 2'd1);
        run("R5 zero",     5'd6, 1'b1, 0, 0, 64'd0, 2'd0);
        run("R5 negative", 5'd6, 1'b1, 0, 0, ONES - 64'd6, 2'd1);
        run("R14 R5 low word zero", 5'd6, 1'b0, 0, 0, 64'h1_0000_0000, 2'd0);
    endtask

    task automatic t_add_sub();
        run("R6 pos ovf",  5'd7, 1'b1, MAXP, 64'd1, MINN, 2'd3);
        run("R6 neg ovf",  5'd7, 1'b1, MINN, ONES, MAXP, 2'd3);
        run("R6 neg res",  5'd7, 1'b1, 64'd2, ONES - 64'd4, ONES - 64'd2, 2'd1);
        run("R6 pos res",  5'd7, 1'b1, 64'd2, 64'd3, 64'd5, 2'd2);
        run("R6 zero res", 5'd7, 1'b1, MINN, MINN, 64'd0, 2'd0);
        run("R14 R6 narrow ovf", 5'd7, 1'b0, 64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 2'd3);
        run("R14 R6 wide same",  5'd7, 1'b1, 64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 2'd2);
        run("R7 pos-neg ovf", 5'd9, 1'b1, MAXP, ONES, MINN, 2'd3);
        run("R7 neg-pos ovf", 5'd9, 1'b1, MINN, 64'd1, MAXP, 2'd3);
        run("R7 neg res",     5'd9, 1'b1, 64'd3, 64'd5, ONES - 64'd1, 2'd1);
        run("R7 zero res",    5'd9, 1'b1, 64'd5, 64'd5, 64'd0, 2'd0);
        run("R7 zero first",  5'd9, 1'b1, 64'd0, MINN, MINN, 2'd1);
        run("R8 zero no carry", 5'd8, 1'b1, 0, 0, 0, 2'd0);
        run("R8 zero carry",    5'd8, 1'b1, ONES, 64'd1, 0, 2'd2);
        run("R8 nz no carry",   5'd8, 1'b1, 64'd1, 64'd2, 64'd3, 2'd1);
        run("R8 nz carry",      5'd8, 1'b1, ONES, 64'd2, 64'd1, 2'd3);
        run("R14 R8 narrow carry", 5'd8, 1'b0, 64'hFFFF_FFFF, 64'd1, 64'h1_0000_0000, 2'd2);
        run("R9 zero",     5'd10, 1'b1, 64'd5, 64'd5, 0, 2'd2);
        run("R9 borrow",   5'd10, 1'b1, 64'd3, 64'd5, ONES - 64'd1, 2'd1);
        run("R9 no borrow", 5'd10, 1'b1, 64'd5, 64'd3, 64'd2, 2'd3);
        run("R14 R9 narrow borrow", 5'd10, 1'b0, 64'h1_0000_0003, 64'd5, 64'h1_FFFF_FFFE, 2'd1);
    endtask

    task automatic t_unary();
        run("R10 min",  5'd11, 1'b1, 0, 0, MINN, 2'd3);
        run("R10 nz",   5'd11, 1'b1, 0, 0, 64'd5, 2'd1);
        run("R10 zero", 5'd11, 1'b1, 0, 0, 64'd0, 2'd0);
        run("R14 R10 narrow min", 5'd11, 1'b0, 0, 0, 64'h8000_0000, 2'd3);
        run("R14 R10 wide not min", 5'd11, 1'b1, 0, 0, 64'h8000_0000, 2'd1);
        run("R11 min",  5'd13, 1'b1, 0, 0, MINN, 2'd3);
        run("R11 neg",  5'd13, 1'b1, 0, 0, ONES - 64'd3, 2'd1);
        run("R11 pos",  5'd13, 1'b1, 0, 0, 64'd4, 2'd2);
        run("R11 zero", 5'd13, 1'b1, 0, 0, 64'd0, 2'd0);
        run("R12 nabs zero", 5'd12, 1'b1, 0, 0, 64'd0, 2'd0);
        run("R12 nabs nz",   5'd12, 1'b1, 0, 0, ONES - 64'd2, 2'd1);
        run("R12 nz wide",   5'd14, 1'b1, 0, 0, 64'h1_0000_0000, 2'd1);
        run("R14 R12 nz narrow", 5'd14, 1'b0, 0, 0, 64'h1_0000_0000, 2'd0);
    endtask

    task automatic t_const_err();
        for (int k = 0; k < 4; k++)
            run("R13 const", 5'(k), 1'b1, ONES, MINN, 64'd1, 2'(k));
        run("R2 unknown 15", 5'd15, 1'b1, 64'd1, 64'd2, 64'd3, 2'd0, 1'b1);
        @(posedge clk); #1 check("R2 err one cycle", 1'b0, 2'd0, 1'b0);
        run("R2 unknown 31", 5'd31, 1'b0, 0, 0, 0, 2'd0, 1'b1);
        run("R2 err cleared", 5'd14, 1'b1, 0, 0, 64'd1, 2'd1);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_cmp();
        t_add_sub();
        t_unary();
        t_const_err();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule